// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block runs as the clock master of a PCM audio link. It produces the bit clock and the frame sync, and it emits a one-cycle strobe on each edge of the bit clock so that the slot engine can shift data in step. Everything runs in the reference clock domain. Both outputs are registered and change only on a reference clock edge.

There are two ways to make the bit clock, and both use one fractional accumulator. In the fixed mode the reference is taken to be 4 MHz. A 2-bit selector then picks one of three standard bit rates, and the frame rate is 8 kHz at every selector value. In the low-jitter mode the reference is taken to be 48 MHz. A 32-bit word then supplies the accumulator step, the accumulator limit and a frame divider, so any bit rate and frame rate inside the field ranges can be set. The sync can be one bit clock long (short frame) or a long pulse of 8 bit clocks. In low-jitter mode it can also be a long pulse of 16 bit clocks. A further bit holds the sync low and leaves the bit clock running.

The first frame starts when the block is enabled. A change to the configuration is applied only where a new frame begins. While the block is disabled, every output stays low.

Top module: `pcm_clk_sync_gen`

## Requirements
- R1: While `en` is low, `pcm_clk`, `pcm_sync`, `rise_stb` and `fall_stb` are all 0 from the next reference edge onward, and the accumulator and frame position return to zero.
- R2: In fixed mode (`ctl[3]`=0), `ctl[1:0]` selects the bit clock: 10 gives 64 bit clocks per frame (512 kHz at a 4 MHz reference), 01 gives 16 (128 kHz), and 00 or 11 gives 32 (256 kHz). Every frame lasts exactly 500 reference cycles.
- R3: The accumulator adds the step on every enabled reference cycle. When the sum reaches the limit, the limit is subtracted and `pcm_clk` toggles. A bit clock period is therefore 2·limit/step reference cycles on average. Fixed mode uses limit 125 and step 32, 16 or 8.
- R4: In low-jitter mode (`ctl[3]`=1), the limit comes from `lj_word[12:0]`, the step from `lj_word[23:16]` and the frame divider from `lj_word[31:24]`. The word 0x08080177 gives 64 bit clocks per frame and 6000 reference cycles per frame (512 kHz bit clock and 8 kHz sync from 48 MHz).
- R5: A frame holds divider×8 bit clocks, and a divider of 0 means 2048 bit clocks. The fixed-mode dividers are 8, 2 and 4 for selectors 10, 01 and 00/11.
- R6: With `ctl[2]`=0 the sync is high for 1 bit clock per frame. With `ctl[2]`=1 it is high for 8 bit clocks. In low-jitter mode `lj_word[13]`=1 lengthens the long sync to 16 bit clocks. In fixed mode that bit has no effect.
- R7: With `ctl[4]`=1, `pcm_sync` stays 0 while `pcm_clk` and the strobes keep running.
- R8: A change on `ctl` or `lj_word` during a frame leaves that frame unchanged and takes effect from the next frame start.
- R9: `rise_stb` is high for exactly the reference cycle in which `pcm_clk` has just gone 0→1, and `fall_stb` is high for the cycle in which it has just gone 1→0. The two strobes are never high together.
- R10: After `en` rises, the first rising edge of `pcm_clk` starts a frame with `pcm_sync` high. In fixed mode with selector 10 this edge appears on the 4th enabled reference edge.
- R11: `pcm_sync` changes only together with a rising edge of `pcm_clk`, or when the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable. While low, all outputs are held low |
| ctl | input | 5 | [1:0] fixed rate select, [2] long sync, [3] low-jitter mode, [4] suppress sync |
| lj_word | input | 32 | Low-jitter settings: [12:0] limit, [13] 16-clock long sync, [23:16] step, [31:24] frame divider |
| pcm_clk | output | 1 | PCM bit clock |
| pcm_sync | output | 1 | PCM frame sync |
| rise_stb | output | 1 | One-cycle strobe on a rising edge of the bit clock |
| fall_stb | output | 1 | One-cycle strobe on a falling edge of the bit clock |

## Verification
Some properties hold on every cycle, and the embedded assertions check these. They cover the quiet outputs while disabled, the link between each bit clock transition and its strobe, sync changes that occur only on rising bit clock edges, and the absence of sync while suppression is latched. Other behaviours can only be seen across a whole frame, and only the directed scenarios show them. These are the bit clock count and reference cycle length of each frame in both modes, the sync widths, the divider-zero wrap, the first frame after enable, and the deferral of a configuration change to the next frame.

// File: rtl/pcm_clk_sync_gen.sv
module pcm_clk_sync_gen #(
  parameter int LIM_W     = 13,
  parameter int RATE_W    = 8,
  parameter int DIV_W     = 8,
  parameter int FIX_LIMIT = 125,
  parameter int FIX_RATE  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [4:0]  ctl,
  input  logic [31:0] lj_word,
  output logic        pcm_clk,
  output logic        pcm_sync,
  output logic        rise_stb,
  output logic        fall_stb
);

  localparam int ACC_W = LIM_W + 1;
  localparam int SUM_W = ACC_W + 1;
  localparam int CNT_W = DIV_W + 3;

  logic [4:0]       act_ctl;
  logic [31:0]      act_word;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] bcnt;
  logic             live;

  function automatic logic [LIM_W-1:0] f_limit(input logic [4:0] c, input logic [31:0] w);
    return c[3] ? w[LIM_W-1:0] : LIM_W'(FIX_LIMIT);
  endfunction

  function automatic logic [RATE_W-1:0] f_rate(input logic [4:0] c, input logic [31:0] w);
    if (c[3]) return w[16 +: RATE_W];
    case (c[1:0])
      2'b10:   return RATE_W'(FIX_RATE);
      2'b01:   return RATE_W'(FIX_RATE / 4);
      default: return RATE_W'(FIX_RATE / 2);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] f_last(input logic [4:0] c, input logic [31:0] w);
    logic [DIV_W-1:0] d;
    if (c[3]) d = w[24 +: DIV_W];
    else begin
      case (c[1:0])
        2'b10:   d = DIV_W'(8);
        2'b01:   d = DIV_W'(2);
        default: d = DIV_W'(4);
      endcase
    end
    return {d, 3'b000} - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] f_wid(input logic [4:0] c, input logic [31:0] w);
    if (!c[2]) return CNT_W'(1);
    return (c[3] && w[13]) ? CNT_W'(16) : CNT_W'(8);
  endfunction

  logic [SUM_W-1:0] sum;
  logic [LIM_W-1:0] lim;
  logic             tog, rising, frame_end;
  logic [4:0]       nxt_ctl;
  logic [31:0]      nxt_word;
  logic [CNT_W-1:0] nxt_cnt;
  logic             unused_bits;

  assign lim       = f_limit(act_ctl, act_word);
  assign sum       = SUM_W'(acc) + SUM_W'(f_rate(act_ctl, act_word));
  assign tog       = sum >= SUM_W'(lim);
  assign rising    = tog && !pcm_clk;
  assign frame_end = !live || (bcnt == f_last(act_ctl, act_word));
  assign nxt_ctl   = frame_end ? ctl : act_ctl;
  assign nxt_word  = frame_end ? lj_word : act_word;
  assign nxt_cnt   = frame_end ? '0 : bcnt + CNT_W'(1);
  assign unused_bits = ^{lj_word[15:14], act_word[15:14]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctl  <= '0;
      act_word <= '0;
      acc      <= '0;
      bcnt     <= '0;
      live     <= 1'b0;
      pcm_clk  <= 1'b0;
      pcm_sync <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else if (!en) begin
      act_ctl  <= ctl;
      act_word <= lj_word;
      acc      <= '0;
      bcnt     <= '0;
      live     <= 1'b0;
      pcm_clk  <= 1'b0;
      pcm_sync <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= rising;
      fall_stb <= tog && pcm_clk;
      acc      <= tog ? ACC_W'(sum - SUM_W'(lim)) : ACC_W'(sum);
      if (tog) pcm_clk <= !pcm_clk;
      if (rising) begin
        live     <= 1'b1;
        bcnt     <= nxt_cnt;
        act_ctl  <= nxt_ctl;
        act_word <= nxt_word;
        pcm_sync <= !nxt_ctl[4] && (nxt_cnt < f_wid(nxt_ctl, nxt_word));
      end
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pcm_clk && !pcm_sync && !rise_stb && !fall_stb));

  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  a_r9_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_clk) |-> rise_stb);

  a_r9_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!pcm_clk && $past(pcm_clk)));

  a_r11_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !rise_stb) |-> $stable(pcm_sync));

  a_r7_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_sync |-> !act_ctl[4]);

endmodule

// File: tb/pcm_clk_sync_gen_tb.sv
module pcm_clk_sync_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [4:0]  ctl = '0;
  logic [31:0] lj_word = '0;
  logic pcm_clk, pcm_sync, rise_stb, fall_stb;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  pcm_clk_sync_gen u_dut (.clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .lj_word(lj_word),
    .pcm_clk(pcm_clk), .pcm_sync(pcm_sync), .rise_stb(rise_stb), .fall_stb(fall_stb));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    bit last = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (rise_stb) begin
        if (pcm_sync && !last) return;
        last = pcm_sync;
      end
    end
  endtask

  task automatic measure(input int chg_at, input logic [4:0] chg_ctl,
                         output int refc, output int pcl, output int wid);
    bit last, pclk_q;
    int bad = 0;
    wait_start();
    refc = 0; pcl = 1; wid = 1; last = 1'b1; pclk_q = pcm_clk;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      refc++;
      if (refc == chg_at) ctl = chg_ctl;
      if (rise_stb && fall_stb) bad++;
      if (rise_stb != (pcm_clk && !pclk_q)) bad++;
      if (fall_stb != (!pcm_clk && pclk_q)) bad++;
      pclk_q = pcm_clk;
      if (rise_stb) begin
        if (pcm_sync && !last) break;
        pcl++;
        if (pcm_sync) wid++;
        last = pcm_sync;
      end
    end
    chk(bad == 0, "R9 strobe mismatches", bad, 0);
  endtask

  task automatic restart(input logic [4:0] c, input logic [31:0] w);
    @(negedge clk); en = 1'b0; ctl = c; lj_word = w;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_reset();
    chk(!pcm_clk && !pcm_sync && !rise_stb && !fall_stb, "R1 reset outputs",
        {pcm_clk, pcm_sync, rise_stb, fall_stb}, 0);
  endtask

  task automatic t_fixed(input logic [1:0] sel, input int exp_pcl);
    int r, p, w;
    restart({2'b00, 1'b1, sel}, 32'h0);
    measure(-1, '0, r, p, w);
    chk(r == 500, "R2 fixed frame ref cycles", r, 500);
    chk(p == exp_pcl, "R2 R5 fixed bit clocks per frame", p, exp_pcl);
    chk(w == 8, "R6 long sync width fixed", w, 8);
  endtask

  task automatic t_lowjit();
    int r, p, w;
    restart(5'b01100, 32'h0808_0177);
    measure(-1, '0, r, p, w);
    chk(r == 6000, "R4 R3 low-jitter frame ref cycles", r, 6000);
    chk(p == 64, "R4 bit clocks per frame", p, 64);
    chk(w == 8, "R6 long sync 8", w, 8);
    restart(5'b01100, 32'h0808_2177);
    measure(-1, '0, r, p, w);
    chk(w == 16, "R6 long sync 16", w, 16);
  endtask

  task automatic t_div();
    int r, p, w;
    restart(5'b01000, 32'h0208_0177);
    measure(-1, '0, r, p, w);
    chk(p == 16, "R5 divider 2", p, 16);
    chk(r == 1500, "R5 divider 2 ref cycles", r, 1500);
    chk(w == 1, "R6 short sync", w, 1);
    restart(5'b01000, 32'h0008_0008);
    measure(-1, '0, r, p, w);
    chk(p == 2048, "R5 divider 0 wraps", p, 2048);
    chk(r == 4096, "R3 step equals limit", r, 4096);
  endtask

  task automatic t_fixed_ignores16();
    int r, p, w;
    restart(5'b00100, 32'h0000_2000);
    measure(-1, '0, r, p, w);
    chk(w == 8, "R6 16-clock bit ignored in fixed", w, 8);
    restart(5'b00000, 32'h0);
    measure(-1, '0, r, p, w);
    chk(w == 1, "R6 fixed short sync", w, 1);
  endtask

  task automatic t_change();
    int r, p, w;
    restart(5'b00110, 32'h0);
    measure(100, 5'b00101, r, p, w);
    chk(p == 64, "R8 change deferred within frame", p, 64);
    chk(r == 500, "R8 frame length kept", r, 500);
    measure(-1, 5'b00101, r, p, w);
    chk(p == 16, "R8 change applied next frame", p, 16);
    chk(r == 500, "R2 frame after change", r, 500);
  endtask

  task automatic t_suppress();
    int rises = 0, highs = 0, seen = 0;
    restart(5'b10100, 32'h0);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rise_stb) rises++;
      if (pcm_sync) highs++;
    end
    chk(highs == 0, "R7 sync held low", highs, 0);
    chk(rises >= 63 && rises <= 65, "R7 clock keeps running", rises, 64);
    ctl = 5'b00100;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (pcm_sync) seen++;
    end
    chk(seen > 0, "R8 R7 sync returns after frame boundary", seen, 1);
  endtask

  task automatic t_disable_first();
    int bad = 0, n = 0;
    @(negedge clk); en = 1'b0; ctl = 5'b00110;
    @(negedge clk);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pcm_clk || pcm_sync || rise_stb || fall_stb) bad++;
    end
    chk(bad == 0, "R1 outputs low while disabled", bad, 0);
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (rise_stb) break;
    end
    chk(n == 4, "R10 first rise cycle", n, 4);
    chk(pcm_sync == 1'b1, "R10 first frame sync", pcm_sync, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_disable_first();
    t_fixed(2'b10, 64);
    t_fixed(2'b00, 32);
    t_fixed(2'b01, 16);
    t_fixed(2'b11, 32);
    t_lowjit();
    t_div();
    t_fixed_ignores16();
    t_change();
    t_suppress();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule